// File: doc/BRIEF.md
# Masked Round-Based AES-128 Encryption Core

This block encrypts one 128-bit block with AES-128 while every intermediate state stays under a Boolean mask. The caller presents the plaintext already combined with two independent 128-bit masks `m` and `m'` (`pt ^ m ^ m'`), the unmasked key and the key mask `m'`. Round keys are expanded one per round beside the datapath and are always applied as `rk ^ m'`. After each key addition the state carries mask `m`.

SubBytes uses sixteen writable 256-entry byte tables, one per state byte. They must hold `T_j(y) = S(y ^ m_j) ^ n_j` with `n = SR^-1(MC^-1(m ^ m'))`. With those contents, ShiftRows followed by MixColumns returns the mask to `m ^ m'`, so no correction step is needed between rounds. The tables are filled beforehand through a write port that writes one address in all sixteen tables per cycle.

Two registers bracket the table stage, so a round takes two cycles. Each register is zeroed in the cycle the other one loads. The result is `ct ^ MC^-1(m ^ m') ^ m'`, which the caller unmasks.

Top module: `aes_masked_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `valid` are 0 and `ct_masked` is all zero.
- R2: A `start` sampled while `busy` is low raises `busy` in the next cycle. `busy` then stays high for exactly 20 cycles (10 rounds of 2 cycles).
- R3: `valid` is high for exactly one cycle, and that cycle is the first one with `busy` low after the encryption.
- R4: A `start` sampled while `busy` is high is ignored. The running encryption keeps its timing and its result.
- R5: For any mask pair with correctly loaded tables, `ct_masked ^ MC^-1(m ^ m') ^ m'` equals the AES-128 ciphertext of the plaintext under the key.
- R6: With both masks zero and the tables loaded with the plain S-box, `ct_masked` equals the plain AES-128 ciphertext.
- R7: `ct_masked` holds its value between `valid` pulses, whatever the other inputs do.
- R8: A table write with `tbl_we` high writes byte j of `tbl_wdata` (bits `127-8j` down to `120-8j`) at `tbl_addr` into the table that serves state byte j. State byte j is row `j%4`, column `j/4`, with byte 0 in the top bits of every 128-bit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption when idle |
| pt_masked | input | 128 | Plaintext masked with m ^ m', sampled at start |
| key | input | 128 | Cipher key, sampled at start |
| key_mask | input | 128 | Mask m' applied to every round key; held constant while busy |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address |
| tbl_wdata | input | 128 | One byte per table, byte j for table j |
| busy | output | 1 | Encryption in progress |
| valid | output | 1 | One-cycle result strobe |
| ct_masked | output | 128 | Masked ciphertext, held until the next result |

## Verification
The core runs first with zero masks and plain S-box tables, so the raw output must match published AES-128 ciphertexts. This separates datapath or key-schedule faults from masking faults. It then runs under several random mask pairs with two known-answer vectors and random plaintexts checked against a behavioural cipher. Because every table byte gets its own mask there, a wrong byte lane, a wrong ShiftRows direction or a missing mask term shows up. A second `start` inside a run, and changes to the inputs after the result, show whether the core ignores a start while busy and holds its output.

// File: rtl/aes_mask_pkg.sv
package aes_mask_pkg;
    localparam int BYTE_W    = 8;
    localparam int NB        = 16;
    localparam int BLK_W     = NB * BYTE_W;
    localparam int WORD_W    = 32;
    localparam int NR        = 10;
    localparam int RND_W     = $clog2(NR + 1);
    localparam int ADDR_W    = BYTE_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ROUND_CYC = 2;
    localparam int BUSY_CYC  = NR * ROUND_CYC;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  block_t;

    typedef struct packed {
        logic load;    // start accepted this cycle
        logic busy;
        logic sub_en;  // table stage captures
        logic mix_en;  // linear layer + key add captures
        logic last;    // final round
    } ctrl_t;

    function automatic byte_t xtime(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t p = '0;
        byte_t x = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ x;
            x = xtime(x);
        end
        return p;
    endfunction

    // inverse as a^254, then the affine map
    function automatic byte_t sbox(byte_t a);
        byte_t sq = a;
        byte_t r  = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq = gmul(sq, sq);
            r  = gmul(r, sq);
        end
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t get_byte(block_t b, int i);
        return b[BLK_W-1-BYTE_W*i -: BYTE_W];
    endfunction

    function automatic block_t shift_rows(block_t b);
        block_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-BYTE_W*(r+4*c) -: BYTE_W] = get_byte(b, r + 4*((c + r) % 4));
        return o;
    endfunction

    function automatic block_t mix_columns(block_t b);
        block_t o;
        byte_t a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = get_byte(b, 4*c);
            a1 = get_byte(b, 4*c+1);
            a2 = get_byte(b, 4*c+2);
            a3 = get_byte(b, 4*c+3);
            o[BLK_W-1-BYTE_W*(4*c)   -: BYTE_W] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
            o[BLK_W-1-BYTE_W*(4*c+1) -: BYTE_W] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
            o[BLK_W-1-BYTE_W*(4*c+2) -: BYTE_W] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
            o[BLK_W-1-BYTE_W*(4*c+3) -: BYTE_W] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
        end
        return o;
    endfunction

    function automatic word_t sub_word(word_t w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    function automatic block_t key_step(block_t rk, byte_t rcon);
        word_t w0, w1, w2, w3, t;
        w0 = rk[BLK_W-1 -: WORD_W];
        w1 = rk[BLK_W-1-WORD_W -: WORD_W];
        w2 = rk[BLK_W-1-2*WORD_W -: WORD_W];
        w3 = rk[BLK_W-1-3*WORD_W -: WORD_W];
        t  = sub_word({w3[WORD_W-9:0], w3[WORD_W-1 -: BYTE_W]}) ^ {rcon, 24'h0};
        w0 = w0 ^ t;
        w1 = w1 ^ w0;
        w2 = w2 ^ w1;
        w3 = w3 ^ w2;
        return {w0, w1, w2, w3};
    endfunction
endpackage

// File: rtl/aes_mask_tables.sv
module aes_mask_tables
    import aes_mask_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  block_t            wdata,
    input  block_t            rd_idx,
    output block_t            rd_data
);
    for (genvar j = 0; j < NB; j++) begin : g_tbl
        localparam int HI = BLK_W - 1 - BYTE_W * j;
        byte_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata[HI -: BYTE_W];
        end

        assign rd_data[HI -: BYTE_W] = mem[rd_idx[HI -: BYTE_W]];
    end
endmodule

// File: rtl/aes_mask_ctrl.sv
module aes_mask_ctrl
    import aes_mask_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctl
);
    logic             busy_q;
    logic             ph_q;
    logic [RND_W-1:0] rnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            rnd_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            ph_q   <= 1'b0;
            rnd_q  <= RND_W'(1);
        end else if (busy_q) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                if (rnd_q == RND_W'(NR)) busy_q <= 1'b0;
                else                     rnd_q  <= rnd_q + RND_W'(1);
            end
        end
    end

    always_comb begin
        ctl.load   = start & ~busy_q;
        ctl.busy   = busy_q;
        ctl.sub_en = busy_q & ~ph_q;
        ctl.mix_en = busy_q & ph_q;
        ctl.last   = (rnd_q == RND_W'(NR));
    end
endmodule

// File: rtl/aes_mask_keysched.sv
module aes_mask_keysched
    import aes_mask_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctrl_t  ctl,
    input  block_t key,
    input  block_t key_mask,
    output block_t rk_masked
);
    block_t rk_q;
    byte_t  rcon_q;

    // one expansion step per round, during the table phase
    always_ff @(posedge clk) begin
        if (rst) begin
            rk_q   <= '0;
            rcon_q <= 8'h01;
        end else if (ctl.load) begin
            rk_q   <= key;
            rcon_q <= 8'h01;
        end else if (ctl.sub_en) begin
            rk_q   <= key_step(rk_q, rcon_q);
            rcon_q <= xtime(rcon_q);
        end
    end

    assign rk_masked = rk_q ^ key_mask;
endmodule

// File: rtl/aes_masked_core.sv
module aes_masked_core
    import aes_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BLK_W-1:0]  pt_masked,
    input  logic [BLK_W-1:0]  key,
    input  logic [BLK_W-1:0]  key_mask,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [BLK_W-1:0]  tbl_wdata,
    output logic              busy,
    output logic              valid,
    output logic [BLK_W-1:0]  ct_masked
);
    ctrl_t  ctl;
    block_t stage_a;   // before the tables, mask m
    block_t stage_b;   // after the tables
    block_t tbl_out;
    block_t rk_m;
    block_t lin_out;
    block_t ct_q;
    logic   valid_q;

    aes_mask_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    aes_mask_keysched u_ks (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .key       (key),
        .key_mask  (key_mask),
        .rk_masked (rk_m)
    );

    aes_mask_tables u_tbl (
        .clk     (clk),
        .we      (tbl_we),
        .addr    (tbl_addr),
        .wdata   (tbl_wdata),
        .rd_idx  (stage_a),
        .rd_data (tbl_out)
    );

    always_comb begin
        lin_out = shift_rows(stage_b);
        if (!ctl.last) lin_out = mix_columns(lin_out);
        lin_out = lin_out ^ rk_m;
    end

    // each stage register is precharged to zero while the other one loads
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= '0;
            stage_b <= '0;
            ct_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (ctl.load) begin
                stage_a <= pt_masked ^ key ^ key_mask;
                stage_b <= '0;
            end else if (ctl.sub_en) begin
                stage_b <= tbl_out;
                stage_a <= '0;
            end else if (ctl.mix_en) begin
                stage_b <= '0;
                if (ctl.last) begin
                    ct_q    <= lin_out;
                    valid_q <= 1'b1;
                end else begin
                    stage_a <= lin_out;
                end
            end
        end
    end

    assign busy      = ctl.busy;
    assign valid     = valid_q;
    assign ct_masked = ct_q;
endmodule

// File: rtl/aes_masked_core_chk.sv
module aes_masked_core_chk
    import aes_mask_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             valid,
    input logic [BLK_W-1:0] ct_masked
);
    localparam int LEN_W = $clog2(BUSY_CYC + 2);
    logic [LEN_W-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= '0;
        else if (busy) busy_len <= busy_len + LEN_W'(1);
        else           busy_len <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !valid && ct_masked == '0));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == LEN_W'(BUSY_CYC)));

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_valid_end_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!busy && $past(busy)));

    p_start_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (start && busy && busy_len != LEN_W'(BUSY_CYC - 1)) |=> busy);

    p_ct_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(ct_masked));
endmodule

bind aes_masked_core aes_masked_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .valid     (valid),
    .ct_masked (ct_masked)
);

// File: tb/aes_masked_core_bench.sv
`timescale 1ns/1ps
module aes_masked_core_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] pt_masked = '0;
    logic [127:0] key = '0;
    logic [127:0] key_mask = '0;
    logic         tbl_we = 1'b0;
    logic [7:0]   tbl_addr = '0;
    logic [127:0] tbl_wdata = '0;
    logic         busy, valid;
    logic [127:0] ct_masked;

    always #2.5 clk = ~clk;

    aes_masked_core u_aes_masked_core (
        .clk(clk), .rst(rst), .start(start), .pt_masked(pt_masked), .key(key),
        .key_mask(key_mask), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .busy(busy), .valid(valid), .ct_masked(ct_masked)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int           mb = 0;      // remaining busy cycles
    bit           mv = 0;      // expected valid
    bit           pending = 0;
    bit           seen_valid = 0;
    logic [127:0] exp_ct, cur_m, cur_mp, held_ct;
    string        cur_req;
    logic [7:0]   sb [256];

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            a = xt(a);
        end
        return r;
    endfunction

    function automatic logic [7:0] bg(logic [127:0] b, int i);
        return b[127-8*i -: 8];
    endfunction

    function automatic logic [127:0] b_sub(logic [127:0] b);
        logic [127:0] o;
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = sb[bg(b, i)];
        return o;
    endfunction

    function automatic logic [127:0] b_sr(logic [127:0] b, bit inv);
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127-8*(r+4*c) -: 8] = bg(b, r + 4*(inv ? (c - r + 4) % 4 : (c + r) % 4));
        return o;
    endfunction

    function automatic logic [127:0] b_mc(logic [127:0] b, bit inv);
        logic [127:0] o;
        logic [7:0] cf [4];
        logic [7:0] acc;
        if (inv) cf = '{8'd14, 8'd11, 8'd13, 8'd9};
        else     cf = '{8'd2, 8'd3, 8'd1, 8'd1};
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                acc = 0;
                for (int k = 0; k < 4; k++) acc ^= mul(cf[(k - r + 4) % 4], bg(b, 4*c + k));
                o[127-8*(4*c+r) -: 8] = acc;
            end
        return o;
    endfunction

    function automatic logic [127:0] b_aes(logic [127:0] pt, logic [127:0] k);
        logic [127:0] s = pt ^ k;
        logic [7:0]   rc = 8'h01;
        logic [31:0]  w [4];
        logic [31:0]  t;
        for (int r = 1; r <= 10; r++) begin
            s = b_sr(b_sub(s), 0);
            if (r < 10) s = b_mc(s, 0);
            for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
            t = {sb[w[3][23:16]], sb[w[3][15:8]], sb[w[3][7:0]], sb[w[3][31:24]]} ^ {rc, 24'h0};
            w[0] ^= t; w[1] ^= w[0]; w[2] ^= w[1]; w[3] ^= w[2];
            k  = {w[0], w[1], w[2], w[3]};
            rc = xt(rc);
            s  = s ^ k;
        end
        return s;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // one clock: model update at the edge, comparison at the falling edge
    task automatic step();
        bit go = start && (mb == 0);
        logic [127:0] got;
        @(posedge clk);
        mv = (mb == 1);
        if (go) mb = 20;
        else if (mb > 0) mb--;
        @(negedge clk);
        chk(busy == (mb != 0), "R2 busy", 128'(busy), 128'(mb != 0));
        chk(valid == mv, "R3 valid", 128'(valid), 128'(mv));
        if (mv) begin
            seen_valid = 1;
            held_ct = ct_masked;
            if (pending) begin
                got = ct_masked ^ b_mc(cur_m ^ cur_mp, 1) ^ cur_mp;
                chk(got == exp_ct, cur_req, got, exp_ct);
                pending = 0;
            end
        end
    endtask

    task automatic load_tables(logic [127:0] m, logic [127:0] mp);
        logic [127:0] n = b_sr(b_mc(m ^ mp, 1), 1);
        cur_m = m; cur_mp = mp;
        for (int a = 0; a < 256; a++) begin
            tbl_we = 1; tbl_addr = 8'(a);
            for (int j = 0; j < 16; j++)
                tbl_wdata[127-8*j -: 8] = sb[8'(a) ^ bg(m, j)] ^ bg(n, j);
            step();
        end
        tbl_we = 0;
    endtask

    task automatic encrypt(logic [127:0] pt, logic [127:0] k, logic [127:0] exp,
                           string req, int dup_at);
        pt_masked = pt ^ cur_m ^ cur_mp; key = k; key_mask = cur_mp;
        exp_ct = exp; cur_req = req; pending = 1; seen_valid = 0;
        start = 1; step(); start = 0;
        for (int i = 0; i < 24 && !seen_valid; i++) begin
            if (i == dup_at) begin
                pt_masked = rnd128();  // R4: second start while running
                start = 1;
            end
            step();
            start = 0;
        end
        chk(seen_valid, "R3 result strobe seen", 128'(seen_valid), 128'(1));
    endtask

    logic [127:0] k_c1 = 128'h000102030405060708090a0b0c0d0e0f;
    logic [127:0] p_c1 = 128'h00112233445566778899aabbccddeeff;
    logic [127:0] c_c1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    logic [127:0] k_b  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] p_b  = 128'h3243f6a8885a308d313198a2e0370734;
    logic [127:0] c_b  = 128'h3925841d02dc09fbdc118597196a0b32;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] pt;
        logic [7:0] inv;
        for (int x = 0; x < 256; x++) begin
            inv = 0;
            for (int y = 1; y < 256; y++) if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
                  ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
        cur_m = '0; cur_mp = '0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset and just after
        chk(!busy && !valid && ct_masked == '0, "R1 in reset", {ct_masked[125:0], busy, valid}, '0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !valid && ct_masked == '0, "R1 after reset", {ct_masked[125:0], busy, valid}, '0);

        // R6: unmasked path, raw output equals the known ciphertext
        load_tables('0, '0);
        encrypt(p_c1, k_c1, c_c1, "R6 zero-mask ciphertext", -1);
        chk(ct_masked == c_c1, "R6 raw output", ct_masked, c_c1);

        // R5 / R8: random mask pairs, per-byte distinct table contents
        for (int t = 0; t < 4; t++) begin
            load_tables(rnd128(), rnd128());
            encrypt(p_c1, k_c1, c_c1, "R5 R8 vector C1", -1);
            encrypt(p_b, k_b, c_b, "R5 R8 vector B", -1);
            pt = rnd128();
            encrypt(pt, k_b, b_aes(pt, k_b), "R5 random plaintext", -1);
        end

        // R4: start while busy is ignored, timing and result unchanged
        encrypt(p_b, k_b, c_b, "R4 result after ignored start", 5);
        encrypt(p_c1, k_c1, c_c1, "R4 result after late start", 18);

        // R7: output held while other inputs move
        for (int i = 0; i < 6; i++) begin
            pt_masked = rnd128(); key = rnd128();
            step();
            chk(ct_masked == held_ct, "R7 output held", ct_masked, held_ct);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule